// File: doc/BRIEF.md
# Equalization Phase and Receiver-Hint Sequencer

This block follows the link rate and the equalization phase of one serial port. It walks the phase state machine through Phase 0, Phase 1 and Phase 2. It then runs Phase 3 when that phase is enabled, and finally reaches a completion state. While it runs, it drives three outputs:
- a 2-bit equalization-control code that tracks the phase number;
- a 3-bit receiver preset-hint that selects manual or triggered receiver-equalizer mode;
- an 18-bit de-emphasis word holding the transmitter coefficients requested of the link partner.

Triggered equalizer mode is requested only in the phase that tunes the local receiver. For an endpoint that is Phase 2, and for a root port it is Phase 3. At every other time the hint carries the manual code 3'b000. This covers power-up, any stay at the first- or second-generation rate, and the phases before the tuning phase after each re-entry to the third-generation rate.

The phase machine has six states:
- **IDLE**: link not equalizing.
- **PH0** to **PH3**: the equalization phases.
- **DONE**: exit to receiver-lock recovery with the control code cleared.

Its transitions are:
- **ENTER**: IDLE to PH0 when the rate rises to the third generation.
- **ADV01**: PH0 to PH1 on an advance pulse.
- **ADV12**: PH1 to PH2 on an advance pulse.
- **ADV23**: PH2 to PH3 on an advance pulse when Phase 3 is enabled.
- **SKIP3**: PH2 to DONE on an advance pulse when Phase 3 is disabled.
- **FIN3**: PH3 to DONE on an advance pulse.
- **DROP**: any state to IDLE whenever the rate is below the third generation.

Top module: `eq_hint_seq`

## Requirements
- R1: While reset is held, and after it, until the first state change: phase_o is 0, eq_ctl_o is 2'b00, rx_hint_o is 3'b000, eq_done_o is 0, and tx_deemph_o holds the preset-8 coefficients.
- R2: rate_i encodes 2'b00 as first generation, 2'b01 as second generation and 2'b1x as third generation. After any clock edge at which rate_i is below the third generation, phase_o is 0 (IDLE) and rx_hint_o is 3'b000. This holds from any state.
- R3: At the first edge at which rate_i is at the third generation after a cycle below it (or after reset), the state moves from IDLE to PH0 (phase_o = 1).
- R4: phase_o encodes IDLE=0, PH0=1, PH1=2, PH2=3, PH3=4, DONE=5. At each edge with phase_adv_i high, PH0 moves to PH1 and PH1 moves to PH2.
- R5: An advance at PH2 moves to PH3 when ph3_en_i is 1 and to DONE when it is 0. An advance at PH3 moves to DONE.
- R6: eq_ctl_o is 0, 1, 2 and 3 in PH0, PH1, PH2 and PH3, and 2'b00 in IDLE and DONE. eq_done_o is 1 only in DONE.
- R7: rx_hint_o is 3'b011 (triggered) when the state is PH2 with is_root_i=0, or PH3 with is_root_i=1. Otherwise it is 3'b000. It changes at the same edge as the state.
- R8: tx_deemph_o is {post[17:12], main[11:6], pre[5:0]} and is updated one edge after preset_ld_i with the preset on preset_i. With step = FS/12 = 5 and FS = 60, the (pre, post) step counts are: P0 (0,3), P1 (0,2), P2 (0,4), P3 (0,1), P4 (0,0), P5 (1,0), P6 (2,0), P7 (1,3), P8 (2,2), P9 (3,0), P10 (0,4). main = FS − pre − post. Codes 11 to 15 give P8.
- R9: phase_adv_i has no effect in IDLE or in DONE. DONE is held while the rate stays at the third generation. tx_deemph_o is unchanged in any cycle without preset_ld_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_i | input | 2 | Current link rate (2'b1x = third generation) |
| is_root_i | input | 1 | 1 = root port role, 0 = endpoint role |
| ph3_en_i | input | 1 | Enables the optional Phase 3 |
| phase_adv_i | input | 1 | One-cycle pulse: current phase finished |
| preset_ld_i | input | 1 | Load pulse for the requested partner preset |
| preset_i | input | 4 | Preset number to request |
| phase_o | output | 3 | Encoded phase state |
| eq_ctl_o | output | 2 | Equalization-control code |
| eq_done_o | output | 1 | Exit to receiver-lock recovery reached |
| rx_hint_o | output | 3 | Receiver preset-hint (3'b000 = manual mode) |
| tx_deemph_o | output | 18 | Requested partner coefficients |

## Verification
The properties assume that is_root_i and ph3_en_i are held steady for as long as the state can be affected by them. They also assume that phase_adv_i is a clean one-cycle pulse sampled at the clock edge. The stimulus changes role and Phase-3 enable only while the rate is held low, so the state is in IDLE when they change. All inputs change only on the falling clock edge. Advance pulses are issued in IDLE and DONE on purpose, and a rate drop is forced in the middle of a phase, so that the ignore and drop rules are exercised at the ports.

// File: rtl/eqs_pkg.sv
package eqs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PH0  = 3'd1,
        ST_PH1  = 3'd2,
        ST_PH2  = 3'd3,
        ST_PH3  = 3'd4,
        ST_DONE = 3'd5
    } eq_state_e;

    localparam int unsigned EC_W = 2;

endpackage

// File: rtl/eqs_rate_track.sv
module eqs_rate_track #(
    parameter int unsigned RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_i,
    output logic              hi_o,
    output logic              entry_o,
    output logic              drop_o
);

    logic prev_hi_q;

    // Third generation is any code with the top bit set.
    assign hi_o = rate_i[RATE_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_hi_q <= 1'b0;
        end else begin
            prev_hi_q <= hi_o;
        end
    end

    assign entry_o = hi_o & ~prev_hi_q;
    assign drop_o  = ~hi_o & prev_hi_q;

endmodule

// File: rtl/eqs_phase_fsm.sv
module eqs_phase_fsm
    import eqs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hi_i,
    input  logic            entry_i,
    input  logic            adv_i,
    input  logic            ph3_en_i,
    output eq_state_e       state_q,
    output eq_state_e       state_d,
    output logic [EC_W-1:0] ec_o,
    output logic            done_o
);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!hi_i) begin
            state_d = ST_IDLE;                          // DROP
        end else begin
            unique case (state_q)
                ST_IDLE: if (entry_i) state_d = ST_PH0; // ENTER
                ST_PH0:  if (adv_i)   state_d = ST_PH1; // ADV01
                ST_PH1:  if (adv_i)   state_d = ST_PH2; // ADV12
                ST_PH2:  if (adv_i)   state_d = ph3_en_i ? ST_PH3 : ST_DONE; // ADV23 / SKIP3
                ST_PH3:  if (adv_i)   state_d = ST_DONE; // FIN3
                ST_DONE:              state_d = ST_DONE;
                default:              state_d = ST_IDLE;
            endcase
        end
    end

    // Output logic
    always_comb begin
        ec_o   = '0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ec_o = 2'd0;
            ST_PH0:  ec_o = 2'd0;
            ST_PH1:  ec_o = 2'd1;
            ST_PH2:  ec_o = 2'd2;
            ST_PH3:  ec_o = 2'd3;
            ST_DONE: begin
                ec_o   = 2'd0;
                done_o = 1'b1;
            end
            default: ec_o = 2'd0;
        endcase
    end

endmodule

// File: rtl/eqs_hint_gen.sv
module eqs_hint_gen
    import eqs_pkg::*;
#(
    parameter int unsigned        HINT_W      = 3,
    parameter logic [HINT_W-1:0]  TRIG_HINT   = 3'b011,
    parameter logic [HINT_W-1:0]  MANUAL_HINT = 3'b000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  eq_state_e         state_d,
    input  logic              is_root_i,
    output logic [HINT_W-1:0] hint_o
);

    logic              tune_local;
    logic [HINT_W-1:0] hint_d;

    // The local receiver is tuned in PH2 for an endpoint and in PH3 for a root port.
    always_comb begin
        tune_local = 1'b0;
        unique case (state_d)
            ST_PH2:  tune_local = ~is_root_i;
            ST_PH3:  tune_local = is_root_i;
            default: tune_local = 1'b0;
        endcase
        hint_d = tune_local ? TRIG_HINT : MANUAL_HINT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hint_o <= MANUAL_HINT;
        end else begin
            hint_o <= hint_d;
        end
    end

endmodule

// File: rtl/eqs_coeff_map.sv
module eqs_coeff_map #(
    parameter int unsigned COEF_W         = 6,
    parameter int unsigned PSEL_W         = 4,
    parameter int unsigned FS             = 60,
    parameter int unsigned DEFAULT_PRESET = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_i,
    input  logic [PSEL_W-1:0]   preset_i,
    output logic [3*COEF_W-1:0] deemph_o
);

    localparam int unsigned STEP  = FS / 12;
    localparam int unsigned NPRE  = 11;
    localparam int unsigned FLD_N = 3;

    // Pre-cursor step count per preset.
    function automatic int unsigned pre_steps(input int unsigned p);
        case (p)
            5:       return 1;
            6:       return 2;
            7:       return 1;
            8:       return 2;
            9:       return 3;
            default: return 0;
        endcase
    endfunction

    // Post-cursor step count per preset.
    function automatic int unsigned post_steps(input int unsigned p);
        case (p)
            0:       return 3;
            1:       return 2;
            2:       return 4;
            3:       return 1;
            7:       return 3;
            8:       return 2;
            10:      return 4;
            default: return 0;
        endcase
    endfunction

    function automatic logic [3*COEF_W-1:0] coeffs(input int unsigned p_in);
        int unsigned p;
        int unsigned pre;
        int unsigned post;
        int unsigned mainc;
        p     = (p_in < NPRE) ? p_in : DEFAULT_PRESET;
        pre   = pre_steps(p) * STEP;
        post  = post_steps(p) * STEP;
        mainc = FS - pre - post;
        return {COEF_W'(post), COEF_W'(mainc), COEF_W'(pre)};
    endfunction

    logic [COEF_W-1:0] fld_d [FLD_N];
    logic [COEF_W-1:0] fld_q [FLD_N];
    logic [3*COEF_W-1:0] word_d;

    assign word_d = coeffs(int'(preset_i));

    // One register per cursor field.
    for (genvar g = 0; g < FLD_N; g++) begin : g_fld
        localparam logic [3*COEF_W-1:0] RST_WORD = coeffs(DEFAULT_PRESET);
        assign fld_d[g] = word_d[g*COEF_W +: COEF_W];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fld_q[g] <= RST_WORD[g*COEF_W +: COEF_W];
            end else if (ld_i) begin
                fld_q[g] <= fld_d[g];
            end
        end
        assign deemph_o[g*COEF_W +: COEF_W] = fld_q[g];
    end

endmodule

// File: rtl/eq_hint_seq.sv
module eq_hint_seq
    import eqs_pkg::*;
#(
    parameter int unsigned       RATE_W    = 2,
    parameter int unsigned       HINT_W    = 3,
    parameter int unsigned       COEF_W    = 6,
    parameter int unsigned       PSEL_W    = 4,
    parameter int unsigned       FS        = 60,
    parameter logic [HINT_W-1:0] TRIG_HINT = 3'b011
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [RATE_W-1:0]   rate_i,
    input  logic                is_root_i,
    input  logic                ph3_en_i,
    input  logic                phase_adv_i,
    input  logic                preset_ld_i,
    input  logic [PSEL_W-1:0]   preset_i,
    output logic [2:0]          phase_o,
    output logic [EC_W-1:0]     eq_ctl_o,
    output logic                eq_done_o,
    output logic [HINT_W-1:0]   rx_hint_o,
    output logic [3*COEF_W-1:0] tx_deemph_o
);

    logic      hi;
    logic      entry;
    logic      drop;
    eq_state_e state_q;
    eq_state_e state_d;

    eqs_rate_track #(.RATE_W(RATE_W)) u_rate (
        .clk     (clk),
        .rst_n   (rst_n),
        .rate_i  (rate_i),
        .hi_o    (hi),
        .entry_o (entry),
        .drop_o  (drop)
    );

    eqs_phase_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_i     (hi),
        .entry_i  (entry),
        .adv_i    (phase_adv_i),
        .ph3_en_i (ph3_en_i),
        .state_q  (state_q),
        .state_d  (state_d),
        .ec_o     (eq_ctl_o),
        .done_o   (eq_done_o)
    );

    eqs_hint_gen #(.HINT_W(HINT_W), .TRIG_HINT(TRIG_HINT)) u_hint (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_d   (state_d),
        .is_root_i (is_root_i),
        .hint_o    (rx_hint_o)
    );

    eqs_coeff_map #(.COEF_W(COEF_W), .PSEL_W(PSEL_W), .FS(FS)) u_coef (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_i     (preset_ld_i),
        .preset_i (preset_i),
        .deemph_o (tx_deemph_o)
    );

    assign phase_o = state_q;

endmodule

// File: rtl/eq_hint_seq_chk.sv
module eq_hint_seq_chk #(
    parameter int unsigned RATE_W = 2,
    parameter int unsigned HINT_W = 3,
    parameter int unsigned COEF_W = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic [RATE_W-1:0]   rate_i,
    input logic                is_root_i,
    input logic                ph3_en_i,
    input logic                phase_adv_i,
    input logic                preset_ld_i,
    input logic [2:0]          phase_o,
    input logic [1:0]          eq_ctl_o,
    input logic                eq_done_o,
    input logic [HINT_W-1:0]   rx_hint_o,
    input logic [3*COEF_W-1:0] tx_deemph_o
);

    // R2: a low rate sends the machine to IDLE with the manual hint
    a_r2_low_rate_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rate_i[RATE_W-1] |=> (phase_o == 3'd0) && (rx_hint_o == '0));

    // R5: PH2 advance without Phase 3 goes straight to DONE
    a_r5_skip_ph3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 3'd3) && phase_adv_i && !ph3_en_i && rate_i[RATE_W-1]
        |=> phase_o == 3'd5);

    // R6: control code cleared and done flag set only in DONE
    a_r6_done_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        eq_done_o |-> (eq_ctl_o == 2'd0) && (phase_o == 3'd5));

    // R7: the triggered hint appears only in the local tuning phase
    a_r7_hint_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_hint_o != '0) |->
        ((phase_o == 3'd3) && !is_root_i) || ((phase_o == 3'd4) && is_root_i));

    // R9: DONE holds while the rate stays high
    a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 3'd5) && rate_i[RATE_W-1] |=> phase_o == 3'd5);

    // R9: coefficients change only on a load
    a_r9_deemph_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !preset_ld_i |=> $stable(tx_deemph_o));

endmodule

bind eq_hint_seq eq_hint_seq_chk #(
    .RATE_W(RATE_W), .HINT_W(HINT_W), .COEF_W(COEF_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rate_i      (rate_i),
    .is_root_i   (is_root_i),
    .ph3_en_i    (ph3_en_i),
    .phase_adv_i (phase_adv_i),
    .preset_ld_i (preset_ld_i),
    .phase_o     (phase_o),
    .eq_ctl_o    (eq_ctl_o),
    .eq_done_o   (eq_done_o),
    .rx_hint_o   (rx_hint_o),
    .tx_deemph_o (tx_deemph_o)
);

// File: tb/eq_hint_seq_tb_top.sv
`timescale 1ns/1ps
module eq_hint_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rate_i = 2'b00;
    logic        is_root_i = 1'b0;
    logic        ph3_en_i = 1'b0;
    logic        phase_adv_i = 1'b0;
    logic        preset_ld_i = 1'b0;
    logic [3:0]  preset_i = 4'd0;
    logic [2:0]  phase_o;
    logic [1:0]  eq_ctl_o;
    logic        eq_done_o;
    logic [2:0]  rx_hint_o;
    logic [17:0] tx_deemph_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #2.5 clk = ~clk;

    eq_hint_seq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rate_i      (rate_i),
        .is_root_i   (is_root_i),
        .ph3_en_i    (ph3_en_i),
        .phase_adv_i (phase_adv_i),
        .preset_ld_i (preset_ld_i),
        .preset_i    (preset_i),
        .phase_o     (phase_o),
        .eq_ctl_o    (eq_ctl_o),
        .eq_done_o   (eq_done_o),
        .rx_hint_o   (rx_hint_o),
        .tx_deemph_o (tx_deemph_o)
    );

    typedef struct packed {
        logic [2:0]  ph;
        logic [1:0]  ec;
        logic        done;
        logic [2:0]  hint;
        logic [17:0] de;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    // Reference model state
    int          m_st = 0;
    bit          m_prev_hi = 1'b0;
    logic [17:0] m_de;

    function automatic logic [17:0] ref_coef(input int p_in);
        int p, pre, post;
        int pre_t[11]  = '{0, 0, 0, 0, 0, 1, 2, 1, 2, 3, 0};
        int post_t[11] = '{3, 2, 4, 1, 0, 0, 0, 3, 2, 0, 4};
        p    = (p_in > 10) ? 8 : p_in;
        pre  = pre_t[p] * 5;
        post = post_t[p] * 5;
        return {6'(post), 6'(60 - pre - post), 6'(pre)};
    endfunction

    function automatic logic [1:0] ref_ec(input int s);
        return (s >= 1 && s <= 4) ? 2'(s - 1) : 2'd0;
    endfunction

    task automatic step(input logic [1:0] rate, input bit adv, input bit ld,
                        input int psel, input string tag);
        bit hi;
        exp_t e;
        @(negedge clk);
        rate_i      = rate;
        phase_adv_i = adv;
        preset_ld_i = ld;
        preset_i    = 4'(psel);
        @(posedge clk);
        hi = rate[1];
        if (!hi) m_st = 0;
        else begin
            case (m_st)
                0: if (!m_prev_hi) m_st = 1;
                1: if (adv) m_st = 2;
                2: if (adv) m_st = 3;
                3: if (adv) m_st = ph3_en_i ? 4 : 5;
                4: if (adv) m_st = 5;
                default: m_st = m_st;
            endcase
        end
        m_prev_hi = hi;
        if (ld) m_de = ref_coef(psel);
        e.ph   = 3'(m_st);
        e.ec   = ref_ec(m_st);
        e.done = (m_st == 5);
        e.hint = ((m_st == 3 && !is_root_i) || (m_st == 4 && is_root_i)) ? 3'b011 : 3'b000;
        e.de   = m_de;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({phase_o, eq_ctl_o, eq_done_o, rx_hint_o, tx_deemph_o} !== e) begin
                fails++;
                $display("FAIL %s: got ph=%0d ec=%0d done=%0b hint=%b de=%h, exp ph=%0d ec=%0d done=%0b hint=%b de=%h",
                         t, phase_o, eq_ctl_o, eq_done_o, rx_hint_o, tx_deemph_o,
                         e.ph, e.ec, e.done, e.hint, e.de);
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: got running, exp finished");
        finish_run();
    end

    initial begin
        m_de = ref_coef(8);
        // R1: reset values
        repeat (3) @(negedge clk);
        checks++;
        if ({phase_o, eq_ctl_o, eq_done_o, rx_hint_o, tx_deemph_o} !==
            {3'd0, 2'd0, 1'b0, 3'b000, ref_coef(8)}) begin
            fails++;
            $display("FAIL R1: got ph=%0d hint=%b de=%h, exp ph=0 hint=000 de=%h",
                     phase_o, rx_hint_o, tx_deemph_o, ref_coef(8));
        end
        @(negedge clk);
        rst_n = 1'b1;
        step(2'b00, 0, 0, 0, "R1 after reset");
        step(2'b01, 1, 0, 0, "R9 adv in IDLE low rate");

        // Endpoint, Phase 3 disabled
        is_root_i = 1'b0; ph3_en_i = 1'b0;
        step(2'b10, 0, 0, 0, "R3 enter PH0");
        step(2'b10, 0, 0, 0, "R4 hold PH0");
        step(2'b10, 1, 0, 0, "R4 PH0 to PH1");
        step(2'b10, 1, 1, 5, "R4 PH1 to PH2 R8 load P5");
        step(2'b10, 0, 0, 0, "R7 endpoint trig hint PH2");
        step(2'b10, 1, 0, 0, "R5 skip PH3 to DONE");
        step(2'b10, 1, 0, 0, "R9 adv ignored in DONE");
        step(2'b11, 0, 0, 0, "R6 DONE ctl clear");
        // Downtrain and re-entry
        step(2'b01, 0, 0, 0, "R2 drop to second gen");
        step(2'b00, 0, 0, 0, "R2 drop to first gen");
        step(2'b10, 0, 0, 0, "R3 re-entry PH0");
        step(2'b10, 1, 0, 0, "R7 PH1 hint manual");
        step(2'b10, 1, 0, 0, "R7 PH2 trig");
        step(2'b00, 0, 0, 0, "R2 drop mid PH2");

        // Root port, Phase 3 enabled
        is_root_i = 1'b1; ph3_en_i = 1'b1;
        step(2'b00, 0, 0, 0, "R2 idle low");
        step(2'b10, 0, 0, 0, "R3 root enter");
        step(2'b10, 1, 0, 0, "R4 root PH1");
        step(2'b10, 1, 0, 0, "R7 root PH2 manual");
        step(2'b10, 1, 0, 0, "R5 PH2 to PH3");
        step(2'b10, 0, 0, 0, "R7 root PH3 trig R6 ctl3");
        step(2'b10, 1, 0, 0, "R5 PH3 to DONE");
        step(2'b10, 0, 0, 0, "R9 DONE hold");
        step(2'b01, 0, 0, 0, "R2 drop from DONE");
        step(2'b10, 0, 0, 0, "R3 root re-entry");
        step(2'b10, 1, 0, 0, "R4 PH1");
        step(2'b10, 1, 0, 0, "R4 PH2");
        step(2'b10, 1, 0, 0, "R5 PH3");
        step(2'b01, 0, 0, 0, "R2 drop mid PH3");

        // Preset table including reserved codes
        for (int p = 0; p < 16; p++) begin
            step(2'b00, 0, 1, p, "R8 preset load");
            step(2'b00, 1, 0, 0, "R9 deemph hold");
        end

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule